// File: doc/BRIEF.md
# Maskable Event Interrupt Controller

This block collects six hardware events into a request register and matches them against an enable register. A single registered interrupt line goes high whenever a request is pending while its enable is on. Four of the events arrive as one-cycle pulses from neighbouring units: timer reaching zero, transmit finished, receive finished and command idle. The other two are derived here by comparing a FIFO fill level against a 6-bit water-level threshold.

A host bus reads and writes both registers. Bit 7 of every write chooses the direction. When it is 1, each flag whose data bit is 1 is set. When it is 0, each such flag is cleared. Flags whose data bit is 0 are untouched, so the host never needs a read-modify-write. Both registers use the same layout: bit 5 timer, bit 4 transmit done, bit 3 receive done, bit 2 command idle, bit 1 high-water alert, bit 0 low-water alert. Bit 6 is unused.

Top module: `irq_ctrl`

## Requirements
- R1: After reset all request flags, all enable bits and `irq_o` are 0.
- R2: A write to the request register (`host_sel`=0) with data bit 7 = 1 sets every request flag whose data bit (5..0) is 1 and leaves the others unchanged, visible from the next cycle.
- R3: A write to the request register with data bit 7 = 0 clears every request flag whose data bit is 1 and leaves the others unchanged.
- R4: Writes to the enable register (`host_sel`=1) follow the same set (bit 7 = 1) and clear (bit 7 = 0) rule as R2 and R3.
- R5: `host_rdata` returns the request flags (`host_rsel`=0) or the enables (`host_rsel`=1) in bits 5..0, and bits 7 and 6 always read 0.
- R6: A pulse on `ev_timer_zero`, `ev_tx_done`, `ev_rx_done` or `ev_cmd_idle` sets request bit 5, 4, 3 or 2 respectively on the next clock edge.
- R7: In every cycle where `fifo_level` >= 64 - `water_level`, request bit 1 (high alert) is set at the next edge.
- R8: In every cycle where `fifo_level` <= `water_level`, request bit 0 (low alert) is set at the next edge.
- R9: `irq_o` equals, one cycle later, the OR over bits 5..0 of (request AND enable). It is active high.
- R10: When a hardware event and a host clear hit the same request flag in the same cycle, the flag ends up set.
- R11: Writes to data bit 6 have no effect in either mode on either register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_sel | input | 1 | Write target: 0 request, 1 enable |
| host_wdata | input | 8 | Write data; bit 7 = set (1) or clear (0) |
| host_rsel | input | 1 | Read target: 0 request, 1 enable |
| host_rdata | output | 8 | Read data, combinational |
| ev_timer_zero | input | 1 | Timer reached zero pulse |
| ev_tx_done | input | 1 | Transmit finished pulse |
| ev_rx_done | input | 1 | Receive finished pulse |
| ev_cmd_idle | input | 1 | Command sequencer idle pulse |
| fifo_level | input | 7 | Current FIFO fill level, 0 to 64 |
| water_level | input | 6 | Alert threshold |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
A host clear and a hardware set can land on the same request flag in one cycle. This is the collision that decides whether an event is lost. The bench provokes it twice. First it pulses the timer event in the same cycle as a clear write to bit 5. Then it holds the FIFO level at the low threshold while clearing bit 0. In both cases the read-back must show the flag still set. A scoreboard model also tracks the one-cycle lag of the interrupt line across these collisions and across enable changes.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  parameter int NUM_SRC    = 6;
  parameter int DATA_W     = 8;
  parameter int MODE_BIT   = 7;
  parameter int FIFO_DEPTH = 64;
  parameter int WL_W       = 6;
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1);

  localparam int B_TIMER = 5;
  localparam int B_TX    = 4;
  localparam int B_RX    = 3;
  localparam int B_IDLE  = 2;
  localparam int B_HI    = 1;
  localparam int B_LO    = 0;

  typedef enum logic {
    SEL_REQ = 1'b0,
    SEL_EN  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         set_mode,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic [W-1:0] host_val;

  always_comb begin
    host_val = q_r;
    if (wr_en) begin
      if (set_mode) host_val = q_r | wr_mask;
      else          host_val = q_r & ~wr_mask;
    end
    // hardware set overrides a concurrent host clear
    q_nxt = host_val | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/irq_fifo_alert.sv
module irq_fifo_alert #(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7,
  parameter int WL_W  = 6
) (
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [WL_W-1:0]  water_level,
  output logic             hi_alert,
  output logic             lo_alert
);
  localparam int CMP_W = LVL_W + 1;
  logic [CMP_W-1:0] lvl_ext;
  logic [CMP_W-1:0] wl_ext;
  logic [CMP_W-1:0] hi_thr;

  always_comb begin
    lvl_ext  = CMP_W'(fifo_level);
    wl_ext   = CMP_W'(water_level);
    hi_thr   = CMP_W'(DEPTH) - wl_ext;
    hi_alert = (lvl_ext >= hi_thr);
    lo_alert = (lvl_ext <= wl_ext);
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  input  logic [W-1:0] en,
  output logic         irq
);
  logic irq_r;
  logic irq_nxt;

  always_comb irq_nxt = |(req & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_r <= 1'b0;
    else        irq_r <= irq_nxt;
  end

  assign irq = irq_r;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rsel,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              ev_timer_zero,
  input  logic              ev_tx_done,
  input  logic              ev_rx_done,
  input  logic              ev_cmd_idle,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [WL_W-1:0]   water_level,
  output logic              irq_o
);
  logic [NUM_SRC-1:0] req_q;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] hw_evt;
  logic [NUM_SRC-1:0] wr_mask;
  logic               set_mode;
  logic               req_wr;
  logic               en_wr;
  logic               hi_alert;
  logic               lo_alert;

  irq_fifo_alert #(
    .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .WL_W(WL_W)
  ) u_alert (
    .fifo_level (fifo_level),
    .water_level(water_level),
    .hi_alert   (hi_alert),
    .lo_alert   (lo_alert)
  );

  always_comb begin
    hw_evt          = '0;
    hw_evt[B_TIMER] = ev_timer_zero;
    hw_evt[B_TX]    = ev_tx_done;
    hw_evt[B_RX]    = ev_rx_done;
    hw_evt[B_IDLE]  = ev_cmd_idle;
    hw_evt[B_HI]    = hi_alert;
    hw_evt[B_LO]    = lo_alert;
    wr_mask  = host_wdata[NUM_SRC-1:0];
    set_mode = host_wdata[MODE_BIT];
    req_wr   = host_wr && (reg_sel_e'(host_sel) == SEL_REQ);
    en_wr    = host_wr && (reg_sel_e'(host_sel) == SEL_EN);
  end

  irq_setclr_reg #(.W(NUM_SRC)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (req_wr),
    .set_mode(set_mode),
    .wr_mask (wr_mask),
    .hw_set  (hw_evt),
    .q       (req_q)
  );

  irq_setclr_reg #(.W(NUM_SRC)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (en_wr),
    .set_mode(set_mode),
    .wr_mask (wr_mask),
    .hw_set  ({NUM_SRC{1'b0}}),
    .q       (en_q)
  );

  irq_combine #(.W(NUM_SRC)) u_comb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req_q),
    .en   (en_q),
    .irq  (irq_o)
  );

  always_comb begin
    host_rdata = '0;
    if (reg_sel_e'(host_rsel) == SEL_EN) host_rdata[NUM_SRC-1:0] = en_q;
    else                                 host_rdata[NUM_SRC-1:0] = req_q;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_sel,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic              ev_timer_zero,
  input logic              ev_tx_done,
  input logic [LVL_W-1:0]  fifo_level,
  input logic [WL_W-1:0]   water_level,
  input logic [NUM_SRC-1:0] req_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic              irq_o
);
  a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(req_q & en_q)));

  a_r5_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[DATA_W-1:NUM_SRC] == '0);

  a_r10_timer_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timer_zero |=> req_q[B_TIMER]);

  a_r6_tx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_done |=> req_q[B_TX]);

  a_r2_req_set: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_sel && host_wdata[MODE_BIT] && host_wdata[B_IDLE])
    |=> req_q[B_IDLE]);

  a_r4_en_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel && !host_wdata[MODE_BIT] && host_wdata[B_TIMER])
    |=> !en_q[B_TIMER]);

  a_r8_low_alert: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, fifo_level} <= {{(LVL_W + 1 - WL_W){1'b0}}, water_level})
    |=> req_q[B_LO]);

  a_r7_high_alert: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, fifo_level} >= ((LVL_W + 1)'(FIFO_DEPTH) - (LVL_W + 1)'(water_level)))
    |=> req_q[B_HI]);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_wr      (host_wr),
  .host_sel     (host_sel),
  .host_wdata   (host_wdata),
  .host_rdata   (host_rdata),
  .ev_timer_zero(ev_timer_zero),
  .ev_tx_done   (ev_tx_done),
  .fifo_level   (fifo_level),
  .water_level  (water_level),
  .req_q        (req_q),
  .en_q         (en_q),
  .irq_o        (irq_o)
);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_sel = 1'b0;
  logic [7:0] host_wdata = '0;
  logic       host_rsel = 1'b0;
  logic [7:0] host_rdata;
  logic       ev_timer_zero = 1'b0;
  logic       ev_tx_done = 1'b0;
  logic       ev_rx_done = 1'b0;
  logic       ev_cmd_idle = 1'b0;
  logic [6:0] fifo_level = 7'd32;
  logic [5:0] water_level = 6'd0;
  logic       irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [5:0] m_req = '0;
  logic [5:0] m_en  = '0;
  logic       m_irq = 1'b0;

  typedef struct {
    string      tag;
    logic [5:0] req;
    logic [5:0] en;
    logic       irq;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  irq_ctrl u_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rsel(host_rsel), .host_rdata(host_rdata),
    .ev_timer_zero(ev_timer_zero), .ev_tx_done(ev_tx_done),
    .ev_rx_done(ev_rx_done), .ev_cmd_idle(ev_cmd_idle),
    .fifo_level(fifo_level), .water_level(water_level), .irq_o(irq_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        host_rsel = 1'b0; #1;
        check(it.tag, "request", host_rdata, {2'b00, it.req});
        host_rsel = 1'b1; #1;
        check(it.tag, "enable", host_rdata, {2'b00, it.en});
        check(it.tag, "irq", {7'd0, irq_o}, {7'd0, it.irq});
      end
    end
  end

  // driver: one clock with the given inputs, model updated from requirements
  task automatic step(input logic wr, input logic sel, input logic [7:0] d,
                      input logic [3:0] ev, input logic [6:0] lvl,
                      input logic [5:0] wl);
    logic [5:0] hw;
    logic [5:0] r_n;
    logic [5:0] e_n;
    host_wr = wr; host_sel = sel; host_wdata = d;
    {ev_timer_zero, ev_tx_done, ev_rx_done, ev_cmd_idle} = ev;
    fifo_level = lvl; water_level = wl;
    @(posedge clk);
    hw = {ev, (int'(lvl) >= 64 - int'(wl)), (int'(lvl) <= int'(wl))};
    r_n = m_req; e_n = m_en;
    if (wr && !sel) r_n = d[7] ? (m_req | d[5:0]) : (m_req & ~d[5:0]);
    if (wr && sel)  e_n = d[7] ? (m_en | d[5:0]) : (m_en & ~d[5:0]);
    m_irq = |(m_req & m_en);
    m_req = r_n | hw;
    m_en  = e_n;
    #1;
    host_wr = 1'b0; host_wdata = '0;
    {ev_timer_zero, ev_tx_done, ev_rx_done, ev_cmd_idle} = 4'b0;
    fifo_level = 7'd32; water_level = 6'd0;
  endtask

  task automatic wreq(input logic [7:0] d); step(1'b1, 1'b0, d, 4'b0, 7'd32, 6'd0); endtask
  task automatic wen(input logic [7:0] d);  step(1'b1, 1'b1, d, 4'b0, 7'd32, 6'd0); endtask
  task automatic idle();                    step(1'b0, 1'b0, 8'h00, 4'b0, 7'd32, 6'd0); endtask

  task automatic expect_now(input string tag);
    exp_t it;
    it.tag = tag; it.req = m_req; it.en = m_en; it.irq = m_irq;
    sb_q.push_back(it);
    @(negedge clk); #3;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_now("R1 reset");

    wreq(8'hA4);                   expect_now("R2 set bits 5,2");
    wreq(8'h04);                   expect_now("R3 clear bit 2");
    wen(8'hA1);                    expect_now("R4 enable set");
    idle();                        expect_now("R9 irq high after enable");
    wen(8'h20);                    expect_now("R4 enable clear");
    idle();                        expect_now("R9 irq low after disable");
    wreq(8'hC0); wen(8'hC0);       expect_now("R11 bit6 set ignored");
    wreq(8'hBF);                   expect_now("R5 read top bits zero");
    wreq(8'h40);                   expect_now("R11 bit6 clear ignored");
    wreq(8'h3F);                   expect_now("R3 clear all");

    step(1'b0, 1'b0, 8'h00, 4'b1000, 7'd32, 6'd0); expect_now("R6 timer event");
    step(1'b0, 1'b0, 8'h00, 4'b0100, 7'd32, 6'd0); expect_now("R6 tx event");
    step(1'b0, 1'b0, 8'h00, 4'b0010, 7'd32, 6'd0); expect_now("R6 rx event");
    step(1'b0, 1'b0, 8'h00, 4'b0001, 7'd32, 6'd0); expect_now("R6 idle event");
    wreq(8'h3F);                   expect_now("R3 clear events");

    step(1'b0, 1'b0, 8'h00, 4'b0, 7'd53, 6'd10); expect_now("R7 below high threshold");
    step(1'b0, 1'b0, 8'h00, 4'b0, 7'd54, 6'd10); expect_now("R7 at high threshold");
    step(1'b0, 1'b0, 8'h00, 4'b0, 7'd64, 6'd0);  expect_now("R7 full with zero level");
    wreq(8'h3F);
    step(1'b0, 1'b0, 8'h00, 4'b0, 7'd11, 6'd10); expect_now("R8 above low threshold");
    step(1'b0, 1'b0, 8'h00, 4'b0, 7'd10, 6'd10); expect_now("R8 at low threshold");
    wreq(8'h3F);

    step(1'b1, 1'b0, 8'h20, 4'b1000, 7'd32, 6'd0); expect_now("R10 timer vs clear");
    step(1'b1, 1'b0, 8'h01, 4'b0000, 7'd5, 6'd5);  expect_now("R10 low alert vs clear");
    wen(8'hBF);
    idle();                        expect_now("R9 all enabled");
    wreq(8'h3F);                   expect_now("R9 irq lags clear");
    idle();                        expect_now("R9 irq low after clear");
    step(1'b0, 1'b0, 8'h00, 4'b0010, 7'd32, 6'd0); idle(); expect_now("R9 rx event to irq");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule